// File: doc/BRIEF.md
# Flash Page Auto-Program Controller

This block is the device-side command and status logic of a byte-wide flash store that is written one whole page of 128 bytes at a time. A host drives a parallel bus made of a chip select, a read strobe, a write strobe, a 17-bit address and 8-bit data. The block samples every bus signal on the rising edge of the system clock, and each clock with select and write both high counts as one write cycle. The host opens a program operation with two write cycles that both carry the program code 0x40. The third write cycle supplies the page address, and the next 128 write cycles carry the page bytes in order. The block holds those bytes in a page buffer, waits out a fixed programming time, and then merges the buffer into the array in one step. Programming can only clear bits, so each stored byte becomes the old byte AND the new byte.

Once the first command write is taken, reads return status instead of array data. Bit 7 shows that programming has ended and bit 6 shows a write error. A misaligned page address still programs the page but raises the error. A second program attempt on a page that has already been programmed also raises the error and leaves the array unchanged. The status stays readable until the host makes its next write cycle. A write of any value other than the program code leaves status mode and returns reads to the array.

Top module: `pgprog_top`

## Requirements
- R1: After reset every array byte reads 0xFF and reads return array data, not status.
- R2: The sequence 0x40, 0x40, page address, then 128 data writes stores byte k of the transfer at offset k of the addressed page. Each stored byte becomes the old byte AND the written byte, and the status then reads 0x80.
- R3: If address bits 6..0 of the address cycle are not all zero, the page selected by the address bits above bit 6 is still programmed, and the final status reads 0xC0 (bit 7 end, bit 6 error).
- R4: A program operation aimed at a page that was already programmed since reset leaves that page unchanged, and the final status reads 0xC0.
- R5: From the last data write until the programming time of PROG_CYCLES clocks has passed, a status read returns bit 7 = 0. Bit 7 returns to 1 when programming ends.
- R6: Write cycles made while programming runs are ignored. The operation ends with its own data and status, and no new sequence starts.
- R7: After an operation ends, the status byte reads the same on every read until the next write cycle. A write of a value other than 0x40 leaves status mode, so reads return array bytes again.
- R8: A write of 0x40 while idle clears both status bits, so status reads 0x00 until a new operation ends.
- R9: If the second command write is not 0x40, the sequence is dropped, reads return array data and nothing is programmed.
- R10: The read data output is 0x00 unless select and read are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all bus signals sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high, qualified by select |
| bus_wr | input | 1 | Write strobe, active high, one write per clock while set with select |
| bus_addr | input | 17 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: array byte, or status in status mode |

## Verification
A wrong sequencer state shows up on the very next status read. The status byte would show bit 7 at the wrong time, or a read that should return status would return array data. A wrong count in the byte or timer counters shows up in one of two ways: bytes land at the wrong offsets, visible in a full page readback, or the end of programming moves away from PROG_CYCLES clocks. A lost or spurious page-used flag does not show until the next program attempt on that page, when bit 6 reads wrong and the page contents change or fail to change.

// File: rtl/pgprog_pkg.sv
package pgprog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD2,
    ST_ADDR,
    ST_LOAD,
    ST_PROG
  } seq_st_e;

  localparam logic [7:0] CMD_PROG = 8'h40;
endpackage

// File: rtl/pgprog_seq.sv
module pgprog_seq
  import pgprog_pkg::*;
#(
  parameter int BYTES       = 128,
  parameter int PROG_CYCLES = 40,
  localparam int CNT_W      = $clog2(BYTES),
  localparam int TMR_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [7:0]       wdata,
  input  logic             misalign,
  input  logic             page_used,
  output logic             cap_addr,
  output logic             ld_en,
  output logic [CNT_W-1:0] ld_idx,
  output logic             commit,
  output logic             in_prog,
  output logic             stat_on,
  output logic             done,
  output logic             err
);
  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             stat_q, stat_d, done_q, done_d, err_q, err_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    tmr_d    = tmr_q;
    stat_d   = stat_q;
    done_d   = done_q;
    err_d    = err_q;
    cap_addr = 1'b0;
    ld_en    = 1'b0;
    commit   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (wr_stb) begin
        done_d = 1'b0;
        err_d  = 1'b0;
        if (wdata == CMD_PROG) begin
          st_d   = ST_CMD2;
          stat_d = 1'b1;
        end else begin
          stat_d = 1'b0;
        end
      end
      ST_CMD2: if (wr_stb) begin
        if (wdata == CMD_PROG) begin
          st_d = ST_ADDR;
        end else begin
          st_d   = ST_IDLE;
          stat_d = 1'b0;
        end
      end
      ST_ADDR: if (wr_stb) begin
        cap_addr = 1'b1;
        cnt_d    = '0;
        st_d     = ST_LOAD;
      end
      ST_LOAD: if (wr_stb) begin
        ld_en = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTES - 1)) begin
          st_d  = ST_PROG;
          tmr_d = '0;
        end
      end
      ST_PROG: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TMR_W'(PROG_CYCLES - 1)) begin
          commit = 1'b1;
          st_d   = ST_IDLE;
          done_d = 1'b1;
          err_d  = misalign | page_used;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      tmr_q  <= '0;
      stat_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tmr_q  <= tmr_d;
      stat_q <= stat_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign ld_idx  = cnt_q;
  assign in_prog = (st_q == ST_PROG);
  assign stat_on = stat_q;
  assign done    = done_q;
  assign err     = err_q;
endmodule

// File: rtl/pgprog_store.sv
module pgprog_store #(
  parameter int BYTES   = 128,
  parameter int NPAGES  = 4,
  localparam int CNT_W  = $clog2(BYTES),
  localparam int PG_W   = (NPAGES > 1) ? $clog2(NPAGES) : 1,
  localparam int AW     = CNT_W + PG_W,
  localparam int DEPTH  = NPAGES * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             commit,
  input  logic [PG_W-1:0]  page,
  input  logic [AW-1:0]    rd_idx,
  output logic [7:0]       rd_byte,
  output logic             page_used,
  output logic [NPAGES-1:0] used_flags
);
  logic [7:0]        pbuf [BYTES];
  logic [7:0]        mem  [DEPTH];
  logic [NPAGES-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (ld_en) begin
      pbuf[ld_idx] <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      used_q <= '0;
    end else if (commit && !used_q[page]) begin
      for (int i = 0; i < BYTES; i++)
        mem[{page, CNT_W'(i)}] <= mem[{page, CNT_W'(i)}] & pbuf[i];
      used_q[page] <= 1'b1;
    end
  end

  assign rd_byte    = mem[rd_idx];
  assign page_used  = used_q[page];
  assign used_flags = used_q;
endmodule

// File: rtl/pgprog_top.sv
module pgprog_top
  import pgprog_pkg::*;
#(
  parameter int BYTES       = 128,
  parameter int NPAGES      = 4,
  parameter int PROG_CYCLES = 40,
  parameter int ADDR_W      = 17,
  localparam int CNT_W      = $clog2(BYTES),
  localparam int PG_W       = (NPAGES > 1) ? $clog2(NPAGES) : 1,
  localparam int AW         = CNT_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  logic             wr_stb, cap_addr, ld_en, commit, in_prog;
  logic             stat_on, done, err, page_used;
  logic [CNT_W-1:0] ld_idx;
  logic [PG_W-1:0]  page_q, page_d;
  logic             mis_q, mis_d;
  logic [7:0]       rd_byte;
  logic [NPAGES-1:0] used_flags;

  assign wr_stb = bus_sel & bus_wr;

  pgprog_seq #(.BYTES(BYTES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(bus_wdata),
    .misalign(mis_q), .page_used(page_used), .cap_addr(cap_addr),
    .ld_en(ld_en), .ld_idx(ld_idx), .commit(commit), .in_prog(in_prog),
    .stat_on(stat_on), .done(done), .err(err)
  );

  always_comb begin
    page_d = page_q;
    mis_d  = mis_q;
    if (cap_addr) begin
      page_d = bus_addr[CNT_W +: PG_W];
      mis_d  = |bus_addr[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      mis_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      mis_q  <= mis_d;
    end
  end

  pgprog_store #(.BYTES(BYTES), .NPAGES(NPAGES)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(bus_wdata), .commit(commit), .page(page_q),
    .rd_idx(bus_addr[AW-1:0]), .rd_byte(rd_byte),
    .page_used(page_used), .used_flags(used_flags)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_sel && bus_rd)
      bus_rdata = stat_on ? {done, err, 6'b0} : rd_byte;
  end
endmodule

// File: rtl/pgprog_chk.sv
module pgprog_chk #(
  parameter int NPAGES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              in_prog,
  input logic              stat_on,
  input logic              done,
  input logic              err,
  input logic [NPAGES-1:0] used_flags
);
  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd) |-> bus_rdata == 8'h00);

  assert_busy_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && bus_sel && bus_rd) |-> bus_rdata[7] == 1'b0);

  assert_end_from_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_prog));

  assert_prog_ignores_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && bus_sel && bus_wr) |=> (in_prog || done));

  assert_cmd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_prog && stat_on && done && bus_sel && bus_wr) |=> (!done && !err));

  assert_once_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(used_flags) & ~used_flags) == '0));

  assert_err_needs_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind pgprog_top pgprog_chk #(.NPAGES(NPAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .in_prog(in_prog), .stat_on(stat_on), .done(done), .err(err),
  .used_flags(used_flags)
);

// File: tb/sim_pgprog_top.sv
module sim_pgprog_top;
  localparam int BYTES = 128;
  localparam int NP    = 4;
  localparam int PC    = 20;

  logic        clk, rst_n, sel, rd, wr;
  logic [16:0] addr;
  logic [7:0]  wdata, rdata;

  int nchk = 0;
  int nbad = 0;
  logic [7:0] ref_mem [NP*BYTES];
  bit         ref_used [NP];
  logic [7:0] pdata [BYTES];

  pgprog_top #(.BYTES(BYTES), .NPAGES(NP), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] stat_byte(bit d, bit e);
    return {d, e, 6'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [16:0] a, logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(posedge clk);
    #1 sel = 0; wr = 0;
  endtask

  task automatic bus_read(logic [16:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; rd = 1; wr = 0; addr = a;
    #2 d = rdata;
    #1 sel = 0; rd = 0;
  endtask

  task automatic run_prog(logic [16:0] a, bit noise, bit exp_err);
    logic [7:0] v;
    int busy;
    int pg;
    pg = int'(a >> 7) % NP;
    bus_write(17'h0, 8'h40);
    bus_write(17'h0, 8'h40);
    bus_write(a, 8'h5A);
    for (int i = 0; i < BYTES; i++) bus_write(17'(i), pdata[i]);
    bus_read(17'h0, v);
    check("R5 busy after load", v, stat_byte(0, 0));
    if (noise) begin
      bus_write(17'h0, 8'h40);
      bus_write(17'h0, 8'h00);
    end
    busy = noise ? 3 : 1;
    v = 8'h00;
    while (!v[7] && busy < PC + 10) begin
      bus_read(17'h0, v);
      if (!v[7]) busy++;
    end
    nchk++;
    if (busy < PC - 2 || busy > PC + 2) begin
      nbad++;
      $display("FAIL R5 busy cycles actual=%0d expected=%0d", busy, PC);
    end
    if (!ref_used[pg]) begin
      for (int i = 0; i < BYTES; i++)
        ref_mem[pg*BYTES+i] = ref_mem[pg*BYTES+i] & pdata[i];
      ref_used[pg] = 1;
    end
    check(exp_err ? "R3/R4 status err" : "R2/R6 status ok", v, stat_byte(1, exp_err));
    bus_read(17'h0, v);
    check("R7 status held", v, stat_byte(1, exp_err));
  endtask

  task automatic check_page(int pg, string req);
    logic [7:0] v;
    for (int i = 0; i < BYTES; i++) begin
      bus_read(17'(pg*BYTES+i), v);
      check(req, v, ref_mem[pg*BYTES+i]);
    end
  endtask

  initial begin
    #(20 * 200000);
    nchk++; nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    sel = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
    for (int i = 0; i < NP*BYTES; i++) ref_mem[i] = 8'hFF;
    for (int p = 0; p < NP; p++) ref_used[p] = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    bus_read(17'h0, v);        check("R1 reset byte", v, 8'hFF);
    bus_read(17'd300, v);      check("R1 reset byte", v, 8'hFF);
    @(negedge clk); #2 check("R10 idle bus", rdata, 8'h00);

    // R2 aligned page 0, random data
    for (int i = 0; i < BYTES; i++) pdata[i] = 8'($urandom);
    run_prog(17'h0000, 0, 0);
    bus_write(17'h0, 8'hFF);
    check_page(0, "R2 page0 data");

    // R3 misaligned into page 1, mostly 0xFF fill
    for (int i = 0; i < BYTES; i++) pdata[i] = (i < 8) ? 8'($urandom) : 8'hFF;
    run_prog(17'h0085, 0, 1);
    bus_write(17'h0, 8'hFF);
    check_page(1, "R3 page1 data");

    // R4 second program of page 0
    for (int i = 0; i < BYTES; i++) pdata[i] = 8'h00;
    run_prog(17'h0000, 0, 1);
    bus_write(17'h0, 8'hFF);
    check_page(0, "R4 page0 unchanged");

    // R6 writes during programming, page 2
    for (int i = 0; i < BYTES; i++) pdata[i] = 8'($urandom);
    run_prog(17'h0100, 1, 0);
    bus_write(17'h0, 8'hFF);
    check_page(2, "R6 page2 data");

    // R8 command write clears status
    bus_write(17'h0, 8'h40);
    bus_read(17'h0, v);        check("R8 status cleared", v, 8'h00);
    // R9 wrong second code drops sequence
    bus_write(17'h0, 8'h11);
    bus_read(17'h0185, v);     check("R9 array read", v, 8'hFF);
    bus_read(17'h0000, v);     check("R9 array read", v, ref_mem[0]);

    // random page 3 confirms it is still unused after R9
    for (int i = 0; i < BYTES; i++) pdata[i] = 8'($urandom);
    run_prog(17'h0180, 0, 0);
    bus_write(17'h0, 8'h22);
    check_page(3, "R2 page3 data");
    check_page(1, "R2 page1 kept");

    @(negedge clk); sel = 0; rd = 1; #2 check("R10 no select", rdata, 8'h00);
    rd = 0;

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule